// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that reports each bus cycle as a 3-bit status code instead of driving its own read, write and acknowledge strobes. It samples the code on every clock. When the code leaves the idle value (111), a new bus cycle has started. The block records the kind of cycle at that moment and drives the active-low command strobe that matches it. The strobe stays asserted until the code returns to idle.

Alongside the strobes, the block drives three more outputs. An address-latch enable pulses for one clock at the start of each cycle. A data-enable output is high while any strobe is active. A direction output tells a transceiver whether data leaves the processor (writes) or enters it (reads, fetches, acknowledges).

Write cycles have an early strobe and a normal strobe. The early strobe lets slow targets start sooner. Halt and idle codes drive no strobe at all.

Top module: `bus_cmd_gen`

## Requirements
- R1: While rst_n is sampled low, all seven strobes are high, and ale_o, den_o and dt_tx_o are low.
- R2: ale_o is high for exactly one clock. This is the clock after the edge where the status is first sampled non-idle following a 111 sample. A change from one non-idle code to another does not pulse it.
- R3: Code 000 (interrupt acknowledge) drives intack_n_o low. It goes low from the second clock of the cycle (ale_o high is the first clock) until the clock after the status returns to 111.
- R4: Code 001 (I/O read) drives ioread_n_o low with the same timing as R3.
- R5: Code 010 (I/O write) drives iowrite_adv_n_o low from the first clock of the cycle, and iowrite_n_o low from the second clock.
- R6: Code 011 (halt) drives no strobe, and den_o stays low. ale_o still pulses.
- R7: Codes 100 (fetch) and 101 (memory read) both drive memread_n_o low with the same timing as R3.
- R8: Code 110 (memory write) drives memwrite_adv_n_o low from the first clock of the cycle, and memwrite_n_o low from the second clock.
- R9: In the clock after the status is sampled as 111, every strobe is high again, and den_o and dt_tx_o are low.
- R10: dt_tx_o is high for the whole of an I/O or memory write cycle and low otherwise. den_o is high exactly when at least one strobe is low.
- R11: A cycle whose status is non-idle for a single sample drives only the advanced write strobe, and only for one clock. Non-write codes drive nothing in that case.
- R12: The command is chosen by the code at cycle start. Later non-idle codes, until the next 111, do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_status | input | 3 | Bus-cycle status code from the processor, 111 = idle |
| ale_o | output | 1 | Address-latch enable, one-clock pulse at cycle start |
| den_o | output | 1 | Data enable, high while any strobe is active |
| dt_tx_o | output | 1 | Data direction, high = processor transmits (write) |
| intack_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| ioread_n_o | output | 1 | I/O read strobe, active low |
| iowrite_n_o | output | 1 | I/O write strobe, active low |
| iowrite_adv_n_o | output | 1 | Early I/O write strobe, active low |
| memread_n_o | output | 1 | Memory read strobe, active low |
| memwrite_n_o | output | 1 | Memory write strobe, active low |
| memwrite_adv_n_o | output | 1 | Early memory write strobe, active low |

## Verification
Suppose the recorded idle history is wrong. Then ale_o fires on a non-idle to non-idle change, or fails to fire, in the very next clock. Suppose instead the latched cycle kind is wrong. Then the wrong early write strobe appears in the first clock of a cycle, or the wrong normal strobe in the second, with dt_tx_o flipping at the same moment. A phase flag stuck or released late shows as a normal strobe arriving a clock early, or surviving past the clock after a 111 sample. The model is compared against every output on every clock, so each such fault is reported within one or two clocks of the code change that exposes it.

// File: rtl/bus_cmd_pkg.sv
// Package: shared types for the bus command generator.
// Assumes a 3-bit status code with 111 meaning the bus is idle.
package bus_cmd_pkg;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] STAT_IDLE = 3'b111;

    typedef enum logic [2:0] {
        CYC_INTACK = 3'd0,
        CYC_IORD   = 3'd1,
        CYC_IOWR   = 3'd2,
        CYC_HALT   = 3'd3,
        CYC_FETCH  = 3'd4,
        CYC_MEMRD  = 3'd5,
        CYC_MEMWR  = 3'd6,
        CYC_IDLE   = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/bus_stat_decode.sv
// Module: bus_stat_decode
// Turns a raw status code into a cycle kind. Purely combinational.
// Assumes each code maps to exactly one kind.
module bus_stat_decode
    import bus_cmd_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    output cyc_kind_e         kind_o
);
    // Map each code onto its cycle kind.
    always_comb begin
        unique case (stat_i)
            3'b000:  kind_o = CYC_INTACK;
            3'b001:  kind_o = CYC_IORD;
            3'b010:  kind_o = CYC_IOWR;
            3'b011:  kind_o = CYC_HALT;
            3'b100:  kind_o = CYC_FETCH;
            3'b101:  kind_o = CYC_MEMRD;
            3'b110:  kind_o = CYC_MEMWR;
            default: kind_o = CYC_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_cycle_track.sv
// Module: bus_cycle_track
// Detects a cycle start (idle to non-idle), latches the cycle kind and
// keeps two phase flags. The early phase starts at the start edge; the
// late phase starts one clock later. Both clear on an idle sample.
// Assumes rst_n is synchronous and active low.
module bus_cycle_track
    import bus_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  cyc_kind_e         kind_i,
    output cyc_kind_e         kind_o,
    output logic              early_o,
    output logic              late_o,
    output logic              ale_o
);
    logic      prev_idle_q;
    logic      early_q;
    logic      late_q;
    logic      ale_q;
    cyc_kind_e kind_q;
    logic      stat_idle;

    assign stat_idle = (stat_i == STAT_IDLE);

    // Track idle history, cycle phase and the latched kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idle_q <= 1'b1;
            early_q     <= 1'b0;
            late_q      <= 1'b0;
            ale_q       <= 1'b0;
            kind_q      <= CYC_IDLE;
        end else begin
            prev_idle_q <= stat_idle;
            if (stat_idle) begin
                early_q <= 1'b0;
                late_q  <= 1'b0;
                ale_q   <= 1'b0;
            end else if (prev_idle_q) begin
                early_q <= 1'b1;
                late_q  <= 1'b0;
                ale_q   <= 1'b1;
                kind_q  <= kind_i;
            end else begin
                ale_q  <= 1'b0;
                late_q <= early_q;
            end
        end
    end

    assign kind_o  = kind_q;
    assign early_o = early_q;
    assign late_o  = late_q;
    assign ale_o   = ale_q;

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_q |=> !ale_q);

    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_idle |=> (!early_q && !late_q));
endmodule

// File: rtl/bus_strobe_drive.sv
// Module: bus_strobe_drive
// Forms the active-low strobes, data enable and direction from the
// latched kind and the two phase flags. Purely combinational.
// Assumes early_i is high whenever late_i is high.
module bus_strobe_drive
    import bus_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind_i,
    input  logic      early_i,
    input  logic      late_i,
    output logic      den_o,
    output logic      dt_tx_o,
    output logic      intack_n_o,
    output logic      ioread_n_o,
    output logic      iowrite_n_o,
    output logic      iowrite_adv_n_o,
    output logic      memread_n_o,
    output logic      memwrite_n_o,
    output logic      memwrite_adv_n_o
);
    logic is_iowr;
    logic is_memwr;
    logic is_rd;

    // Classify the latched kind into strobe families.
    always_comb begin
        is_iowr  = (kind_i == CYC_IOWR);
        is_memwr = (kind_i == CYC_MEMWR);
        is_rd    = (kind_i == CYC_FETCH) || (kind_i == CYC_MEMRD);
    end

    // Drive the strobes in the phase each family calls for.
    always_comb begin
        iowrite_adv_n_o  = !(early_i && is_iowr);
        memwrite_adv_n_o = !(early_i && is_memwr);
        iowrite_n_o      = !(late_i && is_iowr);
        memwrite_n_o     = !(late_i && is_memwr);
        memread_n_o      = !(late_i && is_rd);
        ioread_n_o       = !(late_i && kind_i == CYC_IORD);
        intack_n_o       = !(late_i && kind_i == CYC_INTACK);
        dt_tx_o          = early_i && (is_iowr || is_memwr);
        den_o            = !(iowrite_adv_n_o && memwrite_adv_n_o && iowrite_n_o &&
                             memwrite_n_o && memread_n_o && ioread_n_o && intack_n_o);
    end

    assert_one_input_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!intack_n_o, !ioread_n_o, !memread_n_o}));
endmodule

// File: rtl/bus_cmd_gen.sv
// Module: bus_cmd_gen (top)
// Generates bus command strobes from a processor's status code.
// Assumes the status is synchronous to clk; reset is synchronous, active low.
module bus_cmd_gen
    import bus_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_status,
    output logic       ale_o,
    output logic       den_o,
    output logic       dt_tx_o,
    output logic       intack_n_o,
    output logic       ioread_n_o,
    output logic       iowrite_n_o,
    output logic       iowrite_adv_n_o,
    output logic       memread_n_o,
    output logic       memwrite_n_o,
    output logic       memwrite_adv_n_o
);
    cyc_kind_e dec_kind;
    cyc_kind_e cur_kind;
    logic      early;
    logic      late;

    bus_stat_decode u_dec (
        .stat_i (bus_status),
        .kind_o (dec_kind)
    );

    bus_cycle_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_i  (bus_status),
        .kind_i  (dec_kind),
        .kind_o  (cur_kind),
        .early_o (early),
        .late_o  (late),
        .ale_o   (ale_o)
    );

    bus_strobe_drive u_drv (
        .clk              (clk),
        .rst_n            (rst_n),
        .kind_i           (cur_kind),
        .early_i          (early),
        .late_i           (late),
        .den_o            (den_o),
        .dt_tx_o          (dt_tx_o),
        .intack_n_o       (intack_n_o),
        .ioread_n_o       (ioread_n_o),
        .iowrite_n_o      (iowrite_n_o),
        .iowrite_adv_n_o  (iowrite_adv_n_o),
        .memread_n_o      (memread_n_o),
        .memwrite_n_o     (memwrite_n_o),
        .memwrite_adv_n_o (memwrite_adv_n_o)
    );

    assert_memwr_early_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memwrite_n_o) |-> $past(!memwrite_adv_n_o));

    assert_iowr_early_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iowrite_n_o) |-> $past(!iowrite_adv_n_o));

    assert_dir_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_tx_o) |-> (!iowrite_adv_n_o || !memwrite_adv_n_o));
endmodule

// File: tb/bus_cmd_gen_bench.sv
// Bench: drives status sequences and compares every output on every clock
// against a behavioural model that counts clocks since cycle start.
module bus_cmd_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_status = 3'b111;
    logic       ale_o, den_o, dt_tx_o;
    logic       intack_n_o, ioread_n_o, iowrite_n_o, iowrite_adv_n_o;
    logic       memread_n_o, memwrite_n_o, memwrite_adv_n_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    age = -1;
    int    kind = 7;
    bit    prev_idle = 1;
    string tag = "R1";

    always #2 clk = ~clk;

    bus_cmd_gen u_bus_cmd_gen (
        .clk(clk), .rst_n(rst_n), .bus_status(bus_status),
        .ale_o(ale_o), .den_o(den_o), .dt_tx_o(dt_tx_o),
        .intack_n_o(intack_n_o), .ioread_n_o(ioread_n_o),
        .iowrite_n_o(iowrite_n_o), .iowrite_adv_n_o(iowrite_adv_n_o),
        .memread_n_o(memread_n_o), .memwrite_n_o(memwrite_n_o),
        .memwrite_adv_n_o(memwrite_adv_n_o)
    );

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit wr;
        bit any;
        bit e_inta, e_iord, e_iowr, e_iowa, e_mrd, e_mwr, e_mwa;
        wr     = (age >= 0) && (kind == 2 || kind == 6);
        e_iowa = (age >= 0) && kind == 2;
        e_mwa  = (age >= 0) && kind == 6;
        e_iowr = (age >= 1) && kind == 2;
        e_mwr  = (age >= 1) && kind == 6;
        e_mrd  = (age >= 1) && (kind == 4 || kind == 5);
        e_iord = (age >= 1) && kind == 1;
        e_inta = (age >= 1) && kind == 0;
        any    = e_iowa | e_mwa | e_iowr | e_mwr | e_mrd | e_iord | e_inta;
        check1("ale R2", ale_o, age == 0);
        check1("den R10", den_o, any);
        check1("dt R10", dt_tx_o, wr);
        check1("intack R3", intack_n_o, !e_inta);
        check1("ioread R4", ioread_n_o, !e_iord);
        check1("iowrite R5", iowrite_n_o, !e_iowr);
        check1("iowrite_adv R5", iowrite_adv_n_o, !e_iowa);
        check1("memread R7", memread_n_o, !e_mrd);
        check1("memwrite R8", memwrite_n_o, !e_mwr);
        check1("memwrite_adv R8", memwrite_adv_n_o, !e_mwa);
    endtask

    // One clock: drive the code, update the model at the edge, compare after.
    task automatic step(input logic [2:0] s);
        bus_status = s;
        @(posedge clk);
        if (!rst_n) begin
            age = -1; kind = 7; prev_idle = 1;
        end else begin
            if (s == 3'b111) age = -1;
            else if (prev_idle) begin age = 0; kind = int'(s); end
            else age = age + 1;
            prev_idle = (s == 3'b111);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic run_cycle(input logic [2:0] s, input int len);
        for (int i = 0; i < len; i++) step(s);
        step(3'b111);
        step(3'b111);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        step(3'b110);
        step(3'b000);
        rst_n = 1'b1;
        step(3'b111);
        tag = "R3"; run_cycle(3'b000, 4);
        tag = "R4"; run_cycle(3'b001, 3);
        tag = "R5"; run_cycle(3'b010, 5);
        tag = "R6"; run_cycle(3'b011, 4);
        tag = "R7"; run_cycle(3'b100, 3);
        tag = "R7"; run_cycle(3'b101, 2);
        tag = "R8"; run_cycle(3'b110, 4);
        tag = "R11"; run_cycle(3'b110, 1);
        tag = "R11"; run_cycle(3'b010, 1);
        tag = "R11"; run_cycle(3'b001, 1);
        tag = "R12";
        step(3'b001); step(3'b110); step(3'b000); step(3'b111);
        step(3'b110); step(3'b101); step(3'b011); step(3'b111);
        tag = "R9";
        step(3'b100); step(3'b111); step(3'b000); step(3'b000); step(3'b111);
        tag = "R2";
        step(3'b101); step(3'b111); step(3'b101); step(3'b111);
        tag = "R1";
        step(3'b110); step(3'b110);
        rst_n = 1'b0;
        step(3'b110);
        step(3'b110);
        rst_n = 1'b1;
        tag = "R12";
        step(3'b110); step(3'b111); step(3'b111);
        for (int k = 0; k < 8; k++) begin
            tag = "R10";
            run_cycle(3'(k), 2);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule